// File: doc/BRIEF.md
# Pipeline Exception Commit Controller

This block is the exception control path of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). Faults are never acted on in the stage that detects them. Instead each instruction carries a valid bit, a pending-exception bit, a cause code and its PC down the pipe. The block records the first fault an instruction meets, and later stages only forward it. The memory stage is the single commit point. There, one decision is made each cycle: pass the instruction on, trap on its exception, or take an asynchronous interrupt in its place.

When a trap is taken, the cause and exception-PC registers load on the next edge. The fetch, decode and execute slots are emptied, the trapping instruction does not reach writeback, and the next-PC select is driven to the handler address in the same cycle. The datapath, the memories and the handler code lie outside the block. The block sees only the per-stage fault strobes and drives the redirect, the data-write enable and the writeback valid.

The commit decision is an enumerated value with four named states:
- `CMT_IDLE`: the memory slot is empty.
- `CMT_PASS`: the instruction commits normally.
- `CMT_EXC`: the instruction traps on a synchronous exception.
- `CMT_IRQ`: an interrupt is taken at the instruction.

The decision is recomputed every cycle from the memory slot, so there are no transitions to hold. `CMT_IRQ` outranks `CMT_EXC`, and `CMT_EXC` outranks `CMT_PASS`.

Top module: `exc_commit_ctrl`

## Requirements
- R1: Each instruction's PC moves one stage per clock edge with it. When it traps, `epc_q` takes that PC on the edge that ends its memory-stage cycle.
- R2: The cause codes are 1 for a fetch address fault, 2 for an illegal opcode in decode, 3 for an arithmetic overflow in execute, and 4 for a data address fault in memory. An instruction with one fault traps with that code.
- R3: When one instruction meets faults in several stages, the code of the earliest stage is recorded. Later faults neither overwrite it nor change the outcome.
- R4: An interrupt request while the memory slot holds a valid instruction is taken with cause 0, even if that instruction also has a pending exception. With the memory slot empty, the request is ignored.
- R5: `cause_q` and `epc_q` change only on the edge after a trap. In every other cycle they keep their values.
- R6: A trap empties the fetch, decode and execute slots. None of those instructions reaches writeback or raises a later trap, and `wb_valid` is low on the cycle after the trap.
- R7: In the cycle a trap is decided, `redirect` is 1 and `redirect_pc` equals the handler address (default 0x0000_0800). In all other cycles `redirect` is 0.
- R8: `mem_wr_en` follows `mem_wr_req` for a valid memory-stage instruction that commits. It is 0 for an instruction with a pending or memory-stage exception, or one hit by an interrupt.
- R9: Fault strobes for a stage that holds no valid instruction have no effect.
- R10: After reset, `cause_q` is 0, `epc_q` is 0, `redirect` is 0 and `wb_valid` is 0.
- R11: A fault-free instruction with no interrupt reaches writeback: `wb_valid` is 1 and `wb_pc` is its PC on the cycle after its memory stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Fetch stage holds an instruction |
| fetch_pc | input | PC_W | PC of the fetched instruction |
| fetch_addr_fault | input | 1 | Instruction address fault in fetch |
| dec_illegal | input | 1 | Illegal opcode found in decode |
| exe_overflow | input | 1 | Arithmetic overflow in execute |
| mem_addr_fault | input | 1 | Data address fault in memory stage |
| mem_wr_req | input | 1 | Memory-stage instruction wants to store |
| irq_req | input | 1 | Asynchronous interrupt request |
| redirect | output | 1 | Next-PC select: take the handler address |
| redirect_pc | output | PC_W | Handler address |
| mem_wr_en | output | 1 | Data memory write enable after suppression |
| wb_valid | output | 1 | Writeback stage holds a committed instruction |
| wb_pc | output | PC_W | PC of the writeback instruction |
| cause_q | output | 3 | Cause register |
| epc_q | output | PC_W | Exception PC register |

## Verification
The hardest case to reach from the ports is a trap while younger instructions fill every earlier slot. One of those younger instructions must itself be faulty, so that a missing kill would show up as a second trap that changes the cause and EPC. The bench feeds four back-to-back instructions and gives the second one a fetch fault. It raises a data fault on the oldest one in its memory cycle. It then watches the redirect, the cause/EPC pair and the writeback valid for several cycles. Priority is covered by a vector table in which one instruction carries faults in several stages, with and without an interrupt.

// File: rtl/exc_ctrl_pkg.sv
package exc_ctrl_pkg;
    localparam int CAUSE_W = 3;

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_IRQ     = 3'd0,
        CAUSE_FETCH   = 3'd1,
        CAUSE_ILLEGAL = 3'd2,
        CAUSE_OVF     = 3'd3,
        CAUSE_DADDR   = 3'd4
    } cause_e;

    typedef enum logic [1:0] {
        CMT_IDLE,
        CMT_PASS,
        CMT_EXC,
        CMT_IRQ
    } commit_e;
endpackage

// File: rtl/exc_stage_reg.sv
module exc_stage_reg
    import exc_ctrl_pkg::*;
#(
    parameter int     PC_W       = 32,
    parameter cause_e RAISE_CODE = CAUSE_FETCH
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               kill,
    input  logic               in_valid,
    input  logic               in_exc,
    input  logic [CAUSE_W-1:0] in_cause,
    input  logic [PC_W-1:0]    in_pc,
    input  logic               raise,
    output logic               out_valid,
    output logic               out_exc,
    output logic [CAUSE_W-1:0] out_cause,
    output logic [PC_W-1:0]    out_pc
);
    logic               nxt_exc;
    logic [CAUSE_W-1:0] nxt_cause;

    always_comb begin
        nxt_exc   = in_valid && (in_exc || raise);
        nxt_cause = in_exc ? in_cause : (raise ? RAISE_CODE : '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_exc   <= 1'b0;
            out_cause <= '0;
            out_pc    <= '0;
        end else if (kill) begin
            out_valid <= 1'b0;
            out_exc   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            out_exc   <= nxt_exc;
            out_cause <= nxt_cause;
            out_pc    <= in_pc;
        end
    end

    a_r1_pc_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !kill) |=> (out_valid && out_pc == $past(in_pc)));

    a_r3_keep_first: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_exc && !kill) |=> (out_exc && out_cause == $past(in_cause)));

    a_r9_bubble_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid) |=> (!out_valid && !out_exc));

    a_r6_kill_empties: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> !out_valid);
endmodule

// File: rtl/exc_commit_unit.sv
module exc_commit_unit
    import exc_ctrl_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               m_valid,
    input  logic               m_exc,
    input  logic [CAUSE_W-1:0] m_cause,
    input  logic [PC_W-1:0]    m_pc,
    input  logic               mem_addr_fault,
    input  logic               irq_req,
    output logic               take,
    output logic [CAUSE_W-1:0] cause_q,
    output logic [PC_W-1:0]    epc_q
);
    commit_e            decision;
    logic [CAUSE_W-1:0] nxt_cause;

    always_comb begin
        if (!m_valid)                    decision = CMT_IDLE;
        else if (irq_req)                decision = CMT_IRQ;
        else if (m_exc || mem_addr_fault) decision = CMT_EXC;
        else                             decision = CMT_PASS;
    end

    always_comb begin
        take      = 1'b0;
        nxt_cause = cause_q;
        unique case (decision)
            CMT_IRQ: begin
                take      = 1'b1;
                nxt_cause = CAUSE_IRQ;
            end
            CMT_EXC: begin
                take      = 1'b1;
                nxt_cause = m_exc ? m_cause : CAUSE_DADDR;
            end
            CMT_PASS, CMT_IDLE: begin
                take      = 1'b0;
            end
            default: take = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= '0;
            epc_q   <= '0;
        end else if (take) begin
            cause_q <= nxt_cause;
            epc_q   <= m_pc;
        end
    end

    a_r4_irq_first: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && irq_req) |=> (cause_q == CAUSE_IRQ));

    a_r4_irq_needs_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (!m_valid) |-> !take);

    a_r5_epc_load: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (epc_q == $past(m_pc)));

    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> ($stable(cause_q) && $stable(epc_q)));
endmodule

// File: rtl/exc_commit_ctrl.sv
module exc_commit_ctrl
    import exc_ctrl_pkg::*;
#(
    parameter int          PC_W       = 32,
    parameter logic [31:0] HANDLER_PC = 32'h0000_0800
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fetch_valid,
    input  logic [PC_W-1:0]    fetch_pc,
    input  logic               fetch_addr_fault,
    input  logic               dec_illegal,
    input  logic               exe_overflow,
    input  logic               mem_addr_fault,
    input  logic               mem_wr_req,
    input  logic               irq_req,
    output logic               redirect,
    output logic [PC_W-1:0]    redirect_pc,
    output logic               mem_wr_en,
    output logic               wb_valid,
    output logic [PC_W-1:0]    wb_pc,
    output logic [CAUSE_W-1:0] cause_q,
    output logic [PC_W-1:0]    epc_q
);
    localparam int N_REG = 3;  // decode, execute, memory slots

    logic               st_valid [0:N_REG];
    logic               st_exc   [0:N_REG];
    logic [CAUSE_W-1:0] st_cause [0:N_REG];
    logic [PC_W-1:0]    st_pc    [0:N_REG];
    logic [N_REG-1:0]   raise_vec;
    logic               take;

    assign st_valid[0] = fetch_valid;
    assign st_exc[0]   = 1'b0;
    assign st_cause[0] = '0;
    assign st_pc[0]    = fetch_pc;
    assign raise_vec   = {exe_overflow, dec_illegal, fetch_addr_fault};

    for (genvar i = 1; i <= N_REG; i++) begin : g_slot
        localparam cause_e CODE = (i == 1) ? CAUSE_FETCH :
                                  (i == 2) ? CAUSE_ILLEGAL : CAUSE_OVF;
        exc_stage_reg #(
            .PC_W       (PC_W),
            .RAISE_CODE (CODE)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .kill      (take),
            .in_valid  (st_valid[i-1]),
            .in_exc    (st_exc[i-1]),
            .in_cause  (st_cause[i-1]),
            .in_pc     (st_pc[i-1]),
            .raise     (raise_vec[i-1]),
            .out_valid (st_valid[i]),
            .out_exc   (st_exc[i]),
            .out_cause (st_cause[i]),
            .out_pc    (st_pc[i])
        );
    end

    exc_commit_unit #(.PC_W(PC_W)) u_commit (
        .clk            (clk),
        .rst_n          (rst_n),
        .m_valid        (st_valid[N_REG]),
        .m_exc          (st_exc[N_REG]),
        .m_cause        (st_cause[N_REG]),
        .m_pc           (st_pc[N_REG]),
        .mem_addr_fault (mem_addr_fault),
        .irq_req        (irq_req),
        .take           (take),
        .cause_q        (cause_q),
        .epc_q          (epc_q)
    );

    assign redirect    = take;
    assign redirect_pc = HANDLER_PC[PC_W-1:0];
    assign mem_wr_en   = st_valid[N_REG] && mem_wr_req && !take;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid <= 1'b0;
            wb_pc    <= '0;
        end else begin
            wb_valid <= st_valid[N_REG] && !take;
            wb_pc    <= st_pc[N_REG];
        end
    end

    a_r6_no_wb_after_trap: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> !wb_valid);

    a_r8_store_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid[N_REG] && (st_exc[N_REG] || mem_addr_fault)) |-> !mem_wr_en);

    a_r11_commit_reaches_wb: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid[N_REG] && !redirect) |=> (wb_valid && wb_pc == $past(st_pc[N_REG])));
endmodule

// File: tb/tb_exc_commit_ctrl.sv
module tb_exc_commit_ctrl;
    localparam logic [31:0] HANDLER = 32'h0000_0800;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        fetch_valid, fetch_addr_fault, dec_illegal, exe_overflow;
    logic        mem_addr_fault, mem_wr_req, irq_req;
    logic [31:0] fetch_pc;
    logic        redirect, mem_wr_en, wb_valid;
    logic [31:0] redirect_pc, wb_pc, epc_q;
    logic [2:0]  cause_q;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    exc_commit_ctrl #(.PC_W(32), .HANDLER_PC(HANDLER)) dut (
        .clk(clk), .rst_n(rst_n),
        .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
        .fetch_addr_fault(fetch_addr_fault), .dec_illegal(dec_illegal),
        .exe_overflow(exe_overflow), .mem_addr_fault(mem_addr_fault),
        .mem_wr_req(mem_wr_req), .irq_req(irq_req),
        .redirect(redirect), .redirect_pc(redirect_pc), .mem_wr_en(mem_wr_en),
        .wb_valid(wb_valid), .wb_pc(wb_pc), .cause_q(cause_q), .epc_q(epc_q)
    );

    // bits: [7] fetch fault, [6] illegal, [5] overflow, [4] data fault, [3] irq, [2:0] expected cause
    localparam int NV = 11;
    localparam logic [7:0] VEC [0:NV-1] = '{
        8'b0000_0000, 8'b1000_0001, 8'b0100_0010, 8'b0010_0011,
        8'b0001_0100, 8'b1111_0001, 8'b0101_0010, 8'b0011_0011,
        8'b0000_1000, 8'b0100_1000, 8'b0000_0000
    };

    logic [2:0]  m_cause;
    logic [31:0] m_epc;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic clear_in();
        fetch_valid = 0; fetch_pc = '0; fetch_addr_fault = 0; dec_illegal = 0;
        exe_overflow = 0; mem_addr_fault = 0; mem_wr_req = 0; irq_req = 0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        clear_in();
        rst_n = 0;
        @(negedge clk);
        step(); step();
        rst_n = 1;
        // R10 reset state
        chk("R10 cause", {29'd0, cause_q}, 32'd0);
        chk("R10 epc", epc_q, 32'd0);
        chk("R10 redirect", {31'd0, redirect}, 32'd0);
        chk("R10 wb_valid", {31'd0, wb_valid}, 32'd0);
        m_cause = 3'd0; m_epc = 32'd0;

        // R2 R3 R4 R5 R7 R8 R11: one instruction per vector through an empty pipe
        for (int i = 0; i < NV; i++) begin
            logic [7:0]  v;
            logic [31:0] pc;
            logic        trap;
            v = VEC[i];
            pc = 32'h0000_1000 + 32'(i) * 4;
            trap = |v[7:3];
            fetch_valid = 1; fetch_pc = pc; fetch_addr_fault = v[7];
            step();
            clear_in(); dec_illegal = v[6];
            step();
            clear_in(); exe_overflow = v[5];
            step();
            clear_in(); mem_addr_fault = v[4]; irq_req = v[3]; mem_wr_req = 1;
            #0;
            chk($sformatf("R7 redirect vec%0d", i), {31'd0, redirect}, {31'd0, trap});
            if (trap) chk($sformatf("R7 handler vec%0d", i), redirect_pc, HANDLER);
            chk($sformatf("R8 mem_wr_en vec%0d", i), {31'd0, mem_wr_en}, {31'd0, !trap});
            step();
            clear_in();
            if (trap) begin m_cause = v[2:0]; m_epc = pc; end
            chk($sformatf("R2/R3/R4/R5 cause vec%0d", i), {29'd0, cause_q}, {29'd0, m_cause});
            chk($sformatf("R1/R5 epc vec%0d", i), epc_q, m_epc);
            chk($sformatf("R11 wb_valid vec%0d", i), {31'd0, wb_valid}, {31'd0, !trap});
            if (!trap) chk($sformatf("R11 wb_pc vec%0d", i), wb_pc, pc);
            step();
        end

        // R9: interrupt and fault strobes with an empty pipe
        irq_req = 1; dec_illegal = 1; exe_overflow = 1; mem_addr_fault = 1;
        #0;
        chk("R9/R4 empty redirect", {31'd0, redirect}, 32'd0);
        step();
        clear_in();
        chk("R9 cause kept", {29'd0, cause_q}, {29'd0, m_cause});
        chk("R9 epc kept", epc_q, m_epc);
        // strobes in empty slots must not taint a later clean instruction
        fetch_valid = 1; fetch_pc = 32'h0000_3000;
        exe_overflow = 1;            // execute slot empty this cycle
        step();
        clear_in(); mem_addr_fault = 1; // memory slot empty this cycle
        step();
        clear_in();
        step();
        clear_in();
        #0;
        chk("R9 late clean no trap", {31'd0, redirect}, 32'd0);
        step();
        chk("R9 late clean wb", {31'd0, wb_valid}, 32'd1);

        // R6: trap with every younger slot occupied, younger B carries a fetch fault
        clear_in();
        fetch_valid = 1; fetch_pc = 32'h0000_2000;
        step();
        fetch_pc = 32'h0000_2004; fetch_addr_fault = 1;
        step();
        fetch_pc = 32'h0000_2008; fetch_addr_fault = 0;
        step();
        fetch_pc = 32'h0000_200C; mem_addr_fault = 1; mem_wr_req = 1;
        #0;
        chk("R6 redirect on A", {31'd0, redirect}, 32'd1);
        chk("R8 A store blocked", {31'd0, mem_wr_en}, 32'd0);
        step();
        clear_in();
        chk("R6 cause A", {29'd0, cause_q}, 32'd4);
        chk("R6 epc A", epc_q, 32'h0000_2000);
        for (int k = 0; k < 4; k++) begin
            chk($sformatf("R6 wb empty c%0d", k), {31'd0, wb_valid}, 32'd0);
            chk($sformatf("R6 no second trap c%0d", k), {31'd0, redirect}, 32'd0);
            step();
        end
        chk("R6 epc still A", epc_q, 32'h0000_2000);
        chk("R6 cause still A", {29'd0, cause_q}, 32'd4);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule